// File: doc/BRIEF.md
# Serial CRC-32 Frame Appender

This block sits in a one-bit-wide data path between an upstream bit source and a downstream serial consumer. A sequencing controller raises `start`. The block then accepts a frame of a fixed number of message bits (256 by default). Each accepted bit is forwarded unchanged to the output in the same cycle, and the bit is folded into a CRC-32 register. After the final message bit, the block sends the 32 checksum bits. During that time it holds its upstream ready low, so the source keeps its next bit waiting and nothing is lost between frames.

Downstream backpressure (`out_ready` low) freezes both phases. A message bit is taken only when the source offers it and the consumer accepts it. A checksum bit stays on the output until the consumer accepts it. `done` marks the cycle in which the last checksum bit is accepted, and the block then returns to idle.

There are three states. `PH_IDLE` waits for `start`. `PH_MSG` forwards message bits. `PH_CRC` shifts out the checksum. The transitions are:
- idle to message, on `start` in idle;
- message to checksum, on the final accepted message bit;
- checksum to idle, on the final accepted checksum bit.

Top module: `crc_frame_appender`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle. After reset, `in_ready`, `out_valid`, `out_crc` and `done` are all 0.
- R2: In idle, `start` low keeps `in_ready` and `out_valid` at 0, whatever `in_valid` and `in_bit` do.
- R3: In the message phase, `out_bit` equals `in_bit`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, all in the same cycle. `out_crc` is 0.
- R4: The 32 bits that follow the message are the one's complement of the CRC, sent most significant bit first. The CRC uses polynomial 0x04C11DB7, is preset to 0xFFFFFFFF, and takes the message bits in arrival order, with no bit reflection. `out_crc` is 1 for these bits.
- R5: During the checksum phase, `in_ready` is 0 and `out_valid` is 1.
- R6: A frame consumes exactly 256 accepted input bits. No input bit is accepted between the final message bit and the cycle after `done`.
- R7: `done` is 1 for exactly one cycle, the cycle in which the last checksum bit is accepted. The next cycle is idle.
- R8: While `out_ready` is 0, neither counter advances. In the checksum phase, `out_bit` holds its value.
- R9: If `start` is high in the idle cycle after `done`, the next frame's message phase begins on the following cycle.
- R10: A reset in the middle of a frame returns the block to idle. The next frame then produces a correct checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled in idle) |
| in_bit | input | 1 | Upstream data bit |
| in_valid | input | 1 | Upstream bit offered |
| in_ready | output | 1 | Block takes the upstream bit this cycle |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | Output bit valid |
| out_crc | output | 1 | Output bit belongs to the checksum |
| out_ready | input | 1 | Downstream accepts the output bit |
| done | output | 1 | Last checksum bit accepted this cycle |

## Verification
The message-phase outputs (`out_bit`, `out_valid`, `in_ready`) are combinational from the inputs, so they are due in the same cycle as the stimulus. The bench drives its inputs on the falling edge and samples one nanosecond later, before the rising edge that commits the transfer. Each checksum bit is due in the cycle after the previous checksum bit was accepted, or after the final message bit was accepted. `done` is due in the same cycle as the last accepted checksum bit. The bench keeps its own message and checksum indices and advances them only on cycles where it sees a transfer, so every comparison lines up with the design's register updates, even under random stalls.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MSG  = 2'd1,
        PH_CRC  = 2'd2
    } phase_t;
endpackage

// File: rtl/crc_app_counter.sv
module crc_app_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/crc_app_lfsr.sv
module crc_app_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7,
    parameter logic [W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset,
    input  logic         step,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    logic         fb;
    logic [W-1:0] q_step;

    assign fb = q[W-1] ^ din;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign q_step[i] = POLY[i] & fb;
            end else begin : g_up
                assign q_step[i] = q[i-1] ^ (POLY[i] & fb);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (preset) begin
            q <= SEED;
        end else if (step) begin
            q <= q_step;
        end else if (shift) begin
            q <= {q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/crc_frame_appender.sv
module crc_frame_appender
    import crc_app_pkg::*;
#(
    parameter int          MSG_BITS = 256,
    parameter int          CRC_W    = 32,
    parameter logic [31:0] POLY     = 32'h04C11DB7,
    parameter logic [31:0] SEED     = 32'hFFFFFFFF
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_bit,
    input  logic in_valid,
    output logic in_ready,
    output logic out_bit,
    output logic out_valid,
    output logic out_crc,
    input  logic out_ready,
    output logic done
);
    localparam int MAX_LEN = (MSG_BITS > CRC_W) ? MSG_BITS : CRC_W;
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(MSG_BITS - 1);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

    phase_t            state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [CRC_W-1:0]  crc_q;
    logic              cnt_clr, cnt_inc;
    logic              crc_preset, crc_step, crc_shift;
    logic              msg_xfer, crc_xfer;

    assign msg_xfer = (state_q == PH_MSG) && in_valid && out_ready;
    assign crc_xfer = (state_q == PH_CRC) && out_ready;

    crc_app_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    crc_app_lfsr #(.W(CRC_W), .POLY(POLY[CRC_W-1:0]), .SEED(SEED[CRC_W-1:0])) u_crc (
        .clk    (clk),
        .rst    (rst),
        .preset (crc_preset),
        .step   (crc_step),
        .shift  (crc_shift),
        .din    (in_bit),
        .q      (crc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        crc_preset = 1'b0;
        crc_step   = 1'b0;
        crc_shift  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d    = PH_MSG;
                    cnt_clr    = 1'b1;
                    crc_preset = 1'b1;
                end
            end
            PH_MSG: begin
                if (msg_xfer) begin
                    crc_step = 1'b1;
                    if (cnt == MSG_LAST) begin
                        state_d = PH_CRC;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            PH_CRC: begin
                if (crc_xfer) begin
                    crc_shift = 1'b1;
                    if (cnt == CRC_LAST) begin
                        state_d = PH_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: begin
                state_d = PH_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_bit   = 1'b0;
        out_valid = 1'b0;
        out_crc   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
            end
            PH_MSG: begin
                in_ready  = out_ready;
                out_bit   = in_bit;
                out_valid = in_valid;
            end
            PH_CRC: begin
                out_bit   = ~crc_q[CRC_W-1];
                out_valid = 1'b1;
                out_crc   = 1'b1;
                done      = crc_xfer && (cnt == CRC_LAST);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/crc_app_checker.sv
module crc_app_checker (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_crc,
    input logic out_bit,
    input logic done
);
    a_r5_no_ready_in_crc: assert property (@(posedge clk) disable iff (rst)
        out_crc |-> (!in_ready && out_valid));

    a_r3_ready_follows: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_crc) |-> (in_ready == out_ready));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!out_crc && out_ready && !in_ready) |-> !out_valid);

    a_r7_done_on_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_valid && out_ready && out_crc));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !out_crc && !in_ready));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_crc && !out_ready) |=> (out_crc && $stable(out_bit)));
endmodule

bind crc_frame_appender crc_app_checker u_crc_app_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_crc   (out_crc),
    .out_bit   (out_bit),
    .done      (done)
);

// File: tb/test_crc_frame_appender.sv
module test_crc_frame_appender;
    localparam int NBITS = 256;

    logic clk = 1'b0;
    logic rst, start, in_bit, in_valid, in_ready;
    logic out_bit, out_valid, out_crc, out_ready, done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic msg [NBITS];

    always #2 clk = ~clk;

    crc_frame_appender i_crc_frame_appender (
        .clk(clk), .rst(rst), .start(start), .in_bit(in_bit), .in_valid(in_valid),
        .in_ready(in_ready), .out_bit(out_bit), .out_valid(out_valid),
        .out_crc(out_crc), .out_ready(out_ready), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < NBITS; i++) begin
            logic fb = c[31] ^ msg[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return ~c;
    endfunction

    function automatic bit pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    task automatic check_idle(input string req);
        chk({in_ready, out_valid, out_crc, done} == 4'b0000, req,
            {28'd0, in_ready, out_valid, out_crc, done}, 32'd0);
    endtask

    // pat: 0 random, 1 all zeros, 2 all ones; abort_at < 0 runs to completion
    task automatic run_frame(input int vpct, input int rpct, input int pat,
                             input int abort_at, input string crc_req);
        int idx = 0;
        int cidx = 0;
        logic [31:0] exp_crc;
        bit fin = 1'b0;
        for (int i = 0; i < NBITS; i++)
            msg[i] = (pat == 0) ? 1'($urandom) : (pat == 2);
        exp_crc = ref_crc();
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_bit = 1'b1; out_ready = 1'b1;
        #1 check_idle("R9 idle cycle before message");
        while (!fin) begin
            @(negedge clk);
            start = 1'b0;
            out_ready = pct(rpct);
            if (idx < NBITS) begin
                in_valid = pct(vpct);
                in_bit = in_valid ? msg[idx] : 1'($urandom);
                #1;
                chk(!out_crc && !done && out_valid == in_valid && in_ready == out_ready,
                    "R3", {28'd0, out_valid, in_ready, out_crc, done},
                    {28'd0, in_valid, out_ready, 2'b00});
                if (in_valid)
                    chk(out_bit == in_bit, "R3 pass bit", {31'd0, out_bit}, {31'd0, in_bit});
                if (in_valid && out_ready) idx++;
                if (abort_at >= 0 && idx >= abort_at) fin = 1'b1;
            end else begin
                in_valid = 1'b1;
                in_bit = 1'($urandom);
                #1;
                chk(out_crc && out_valid && !in_ready, "R5",
                    {29'd0, out_crc, out_valid, in_ready}, 32'd6);
                chk(out_bit == exp_crc[31-cidx], crc_req, {31'd0, out_bit},
                    {31'd0, exp_crc[31-cidx]});
                chk(done == (out_ready && cidx == 31), "R7", {31'd0, done},
                    {31'd0, 1'(out_ready && cidx == 31)});
                if (out_ready) begin
                    if (cidx == 31) fin = 1'b1;
                    cidx++;
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; in_bit = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check_idle("R1");

        // R2: no start, source offering bits
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_bit = 1'($urandom); out_ready = 1'($urandom);
            #1 check_idle("R2");
        end

        run_frame(100, 100, 1, -1, "R4 zeros");
        run_frame(100, 100, 2, -1, "R4 ones");       // back-to-back: R9
        run_frame(70, 60, 0, -1, "R4 random");
        run_frame(50, 30, 0, -1, "R8 stalled");
        run_frame(90, 90, 0, -1, "R6 random");
        @(negedge clk);
        start = 1'b0; in_valid = 1'b1;
        #1 check_idle("R6 idle after frame");

        // R10: reset mid frame
        run_frame(80, 80, 0, 100, "R10");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b1;
        #1 check_idle("R10 after reset");
        run_frame(80, 70, 0, -1, "R10 crc");
        run_frame(40, 50, 0, -1, "R4 random2");
        @(negedge clk);
        start = 1'b0;
        #1 check_idle("R7 idle after done");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule